// File: doc/BRIEF.md
# Synchronizable Single-Output PWM Timer

This block is a free-running up-counter that drives one PWM output. Two active registers set the waveform: the period limit and the compare threshold. Software normally writes the shadow copies of both. Those shadow values reach the active registers only on the clock where the running counter equals the active period. A direct write path to the active registers exists for initial setup.

An external sync pulse can reload the counter from a phase register, so several timers can be lined up against one master. The block can forward that sync pulse to the next timer in a chain, or send out its own period match instead.

Because both the shadow transfer and the period event depend on a period match, a sync that keeps restarting the counter below the period blocks both of them. The block keeps this behaviour and makes it visible: it brings out a load strobe, the active register values and the event flag, so a system can detect the stall.

Top module: `spwm_timer`

## Requirements
- R1: After reset, the following are all zero: the counter, both active registers, both shadow registers, the phase, every control bit, the event flag and the interrupt. With those values, `pwm_out` and `sync_out` are both 0.
- R2: The counter steps through 0 to P, where P is the active period, so one cycle lasts P+1 clocks. With CTRL bit1 = 0 (active-high), `pwm_out` is 1 while the counter is below the active compare value and 0 otherwise. With CTRL bit1 = 1, the output is inverted.
- R3: The shadow period (address 3) and shadow compare (address 4) are copied into the active period and active compare only at the clock edge that ends a running cycle in which the counter equals the active period. `shadow_load` is high during that cycle. A write to the active period (address 1) or active compare (address 2) takes effect at once.
- R4: When the running counter equals the active period, it becomes 0 on the next clock, unless a sync reload happens in the same cycle.
- R5: With CTRL bit2 = 1, a high `sync_in` loads the counter from the phase register (address 5) on the next edge. This has priority over the wrap and the increment, and it also applies while the timer is stopped. With CTRL bit2 = 0, `sync_in` has no effect on the counter.
- R6: A period match while running sets `prd_evt`, even when a sync reload happens in the same cycle. Writing a 1 to bit0 of the CLEAR register (address 7) clears it.
- R7: `irq` becomes 1 when INTEN bit0 (address 6) is 1 and the event flag is set or being set. Writing a 1 to CLEAR bit1 clears it. If the event flag is still pending and enabled, `irq` sets again on the next clock. With INTEN bit0 = 0, `irq` stays 0.
- R8: CTRL bit0 is the run bit. While it is 0, the counter holds its value, and no period match, shadow transfer or event can occur.
- R9: CTRL bits[4:3] select `sync_out`: 0 forwards `sync_in`, 1 outputs the period-match pulse, and 2 or 3 hold it at 0.
- R10: If sync reloads keep restarting the counter below the active period, the active registers keep their values and `prd_evt` stays 0 however many cycles pass. The first match after the syncs stop performs the pending transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 CTRL, 1 active period, 2 active compare, 3 shadow period, 4 shadow compare, 5 phase, 6 INTEN, 7 CLEAR |
| wr_data | input | CNT_W | Write data |
| sync_in | input | 1 | Sync pulse from the previous timer |
| pwm_out | output | 1 | PWM waveform |
| sync_out | output | 1 | Sync pulse to the next timer |
| irq | output | 1 | Interrupt (global flag) |
| prd_evt | output | 1 | Period-match event flag |
| shadow_load | output | 1 | High in the cycle whose edge performs the shadow transfer |
| cnt_out | output | CNT_W | Counter value |
| act_prd_out | output | CNT_W | Active period |
| act_cmp_out | output | CNT_W | Active compare |

## Verification
The bound checker checks the following on every clock:
- the active period moves only on a load strobe or a direct write, and takes the shadow value when it does;
- the counter wraps to zero after a match, reloads the phase after an enabled sync, and freezes while stopped;
- the event flag and the interrupt rise only from a match and an enable.

Some behaviour shows only over many cycles, and only the bench scenarios can exercise it. This covers the duty and polarity counts across whole periods, the indefinite stall of the transfer under repeated early syncs, and the interrupt setting again after a partial clear.

// File: rtl/spwm_pkg.sv
`timescale 1ns/1ps
package spwm_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [2:0] {
    RA_CTRL    = 3'd0,
    RA_ACT_PRD = 3'd1,
    RA_ACT_CMP = 3'd2,
    RA_SHD_PRD = 3'd3,
    RA_SHD_CMP = 3'd4,
    RA_PHASE   = 3'd5,
    RA_INTEN   = 3'd6,
    RA_CLEAR   = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    SO_PASS  = 2'd0,
    SO_MATCH = 2'd1,
    SO_OFF_A = 2'd2,
    SO_OFF_B = 2'd3
  } sync_sel_e;

  // bit0 run, bit1 active-low, bit2 sync enable, bits[4:3] sync-out select
  typedef struct packed {
    sync_sel_e so_sel;
    logic      sync_en;
    logic      act_low;
    logic      run;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/spwm_regs.sv
`timescale 1ns/1ps
module spwm_regs
  import spwm_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              load_en,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  act_prd,
  output logic [CNT_W-1:0]  act_cmp,
  output logic [CNT_W-1:0]  shd_prd,
  output logic [CNT_W-1:0]  phase,
  output logic              int_en,
  output logic              clr_evt,
  output logic              clr_glb
);
  localparam int unsigned NPAIR = 2;

  ctrl_t            ctrl_d, ctrl_q;
  logic [CNT_W-1:0] phase_d, phase_q;
  logic             inten_d, inten_q;
  logic [CNT_W-1:0] act_arr [NPAIR];
  logic [CNT_W-1:0] shd_arr [NPAIR];

  // next state for the plain configuration registers
  always_comb begin
    ctrl_d  = ctrl_q;
    phase_d = phase_q;
    inten_d = inten_q;
    if (wr_en) begin
      case (wr_addr)
        RA_CTRL:  ctrl_d  = ctrl_t'(wr_data[CTRL_W-1:0]);
        RA_PHASE: phase_d = wr_data;
        RA_INTEN: inten_d = wr_data[0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= ctrl_t'('0);
      phase_q <= '0;
      inten_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      phase_q <= phase_d;
      inten_q <= inten_d;
    end
  end

  // index 0: period pair, index 1: compare pair
  for (genvar gi = 0; gi < NPAIR; gi++) begin : g_pair
    localparam logic [ADDR_W-1:0] A_ACT = ADDR_W'(int'(RA_ACT_PRD) + gi);
    localparam logic [ADDR_W-1:0] A_SHD = ADDR_W'(int'(RA_SHD_PRD) + gi);

    logic [CNT_W-1:0] act_d, act_q, shd_d, shd_q;
    logic             act_wr, shd_wr;

    assign act_wr = wr_en && (wr_addr == A_ACT);
    assign shd_wr = wr_en && (wr_addr == A_SHD);

    always_comb begin
      shd_d = shd_q;
      if (shd_wr) shd_d = wr_data;
      act_d = act_q;
      if (load_en) act_d = shd_q;
      if (act_wr)  act_d = wr_data;   // direct write wins over transfer
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_q <= '0;
        shd_q <= '0;
      end else begin
        act_q <= act_d;
        shd_q <= shd_d;
      end
    end

    assign act_arr[gi] = act_q;
    assign shd_arr[gi] = shd_q;
  end

  assign ctrl    = ctrl_q;
  assign phase   = phase_q;
  assign int_en  = inten_q;
  assign act_prd = act_arr[0];
  assign act_cmp = act_arr[1];
  assign shd_prd = shd_arr[0];
  assign clr_evt = wr_en && (wr_addr == RA_CLEAR) && wr_data[0];
  assign clr_glb = wr_en && (wr_addr == RA_CLEAR) && wr_data[1];
endmodule

// File: rtl/spwm_counter.sv
`timescale 1ns/1ps
module spwm_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             sync_en,
  input  logic             sync_in,
  input  logic [CNT_W-1:0] phase,
  input  logic [CNT_W-1:0] act_prd,
  output logic [CNT_W-1:0] cnt,
  output logic             match,
  output logic             sync_load
);
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             at_prd;

  assign at_prd    = (cnt_q == act_prd);
  assign match     = run && at_prd;
  assign sync_load = sync_en && sync_in;

  // priority: sync reload, then stop, then wrap, then increment
  always_comb begin
    if (sync_load)   cnt_d = phase;
    else if (!run)   cnt_d = cnt_q;
    else if (at_prd) cnt_d = '0;
    else             cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/spwm_wave.sv
`timescale 1ns/1ps
module spwm_wave
  import spwm_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] act_cmp,
  input  logic             act_low,
  input  sync_sel_e        so_sel,
  input  logic             sync_in,
  input  logic             match,
  output logic             pwm_out,
  output logic             sync_out
);
  logic below_cmp;

  always_comb begin
    below_cmp = (cnt < act_cmp);
    pwm_out   = below_cmp ^ act_low;
    case (so_sel)
      SO_PASS:  sync_out = sync_in;
      SO_MATCH: sync_out = match;
      default:  sync_out = 1'b0;
    endcase
  end
endmodule

// File: rtl/spwm_flags.sv
`timescale 1ns/1ps
module spwm_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic int_en,
  input  logic clr_evt,
  input  logic clr_glb,
  output logic evt,
  output logic glb
);
  logic evt_d, evt_q, glb_d, glb_q;

  // a new event wins over a clear in the same cycle
  always_comb begin
    if (match)        evt_d = 1'b1;
    else if (clr_evt) evt_d = 1'b0;
    else              evt_d = evt_q;

    if (match && int_en) glb_d = 1'b1;
    else if (clr_glb)    glb_d = 1'b0;
    else                 glb_d = glb_q | (evt_q & int_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= 1'b0;
      glb_q <= 1'b0;
    end else begin
      evt_q <= evt_d;
      glb_q <= glb_d;
    end
  end

  assign evt = evt_q;
  assign glb = glb_q;
endmodule

// File: rtl/spwm_timer.sv
`timescale 1ns/1ps
module spwm_timer
  import spwm_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              sync_in,
  output logic              pwm_out,
  output logic              sync_out,
  output logic              irq,
  output logic              prd_evt,
  output logic              shadow_load,
  output logic [CNT_W-1:0]  cnt_out,
  output logic [CNT_W-1:0]  act_prd_out,
  output logic [CNT_W-1:0]  act_cmp_out
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] act_prd, act_cmp, shd_prd, phase, cnt;
  logic             int_en, clr_evt, clr_glb, match, sync_load;
  logic             run_c, sync_en_c;

  assign run_c     = ctrl.run;
  assign sync_en_c = ctrl.sync_en;

  spwm_regs #(.CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load_en(match), .ctrl(ctrl),
    .act_prd(act_prd), .act_cmp(act_cmp), .shd_prd(shd_prd),
    .phase(phase), .int_en(int_en), .clr_evt(clr_evt), .clr_glb(clr_glb)
  );

  spwm_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .run(run_c), .sync_en(sync_en_c),
    .sync_in(sync_in), .phase(phase), .act_prd(act_prd),
    .cnt(cnt), .match(match), .sync_load(sync_load)
  );

  spwm_wave #(.CNT_W(CNT_W)) wave_i (
    .cnt(cnt), .act_cmp(act_cmp), .act_low(ctrl.act_low),
    .so_sel(ctrl.so_sel), .sync_in(sync_in), .match(match),
    .pwm_out(pwm_out), .sync_out(sync_out)
  );

  spwm_flags flags_i (
    .clk(clk), .rst_n(rst_n), .match(match), .int_en(int_en),
    .clr_evt(clr_evt), .clr_glb(clr_glb), .evt(prd_evt), .glb(irq)
  );

  assign shadow_load = match;
  assign cnt_out     = cnt;
  assign act_prd_out = act_prd;
  assign act_cmp_out = act_cmp;
endmodule

// File: rtl/spwm_timer_chk.sv
`timescale 1ns/1ps
module spwm_timer_chk
  import spwm_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              sync_in,
  input logic              irq,
  input logic              prd_evt,
  input logic              shadow_load,
  input logic [CNT_W-1:0]  cnt_out,
  input logic [CNT_W-1:0]  act_prd_out,
  input logic              run,
  input logic              sync_en,
  input logic [CNT_W-1:0]  phase,
  input logic [CNT_W-1:0]  shd_prd,
  input logic              int_en
);
  logic prd_direct, reload;
  assign prd_direct = wr_en && (wr_addr == RA_ACT_PRD);
  assign reload     = sync_en && sync_in;

  AST_SHADOW_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_load && !prd_direct |=> act_prd_out == $past(shd_prd)); // R3
  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shadow_load && !prd_direct |=> $stable(act_prd_out)); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    run && (cnt_out == act_prd_out) && !reload |=> cnt_out == '0); // R4
  AST_SYNC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> cnt_out == $past(phase)); // R5
  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !reload |=> $stable(cnt_out)); // R8
  AST_EVT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prd_evt) |-> $past(shadow_load)); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(int_en)); // R7
endmodule

bind spwm_timer spwm_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .sync_in(sync_in), .irq(irq), .prd_evt(prd_evt),
  .shadow_load(shadow_load), .cnt_out(cnt_out), .act_prd_out(act_prd_out),
  .run(run_c), .sync_en(sync_en_c), .phase(phase), .shd_prd(shd_prd),
  .int_en(int_en)
);

// File: tb/spwm_timer_tb_top.sv
`timescale 1ns/1ps
module spwm_timer_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [2:0]   wr_addr;
  logic [W-1:0] wr_data;
  logic         sync_in;
  logic         pwm_out, sync_out, irq, prd_evt, shadow_load;
  logic [W-1:0] cnt_out, act_prd_out, act_cmp_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  spwm_timer #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sync_in(sync_in), .pwm_out(pwm_out),
    .sync_out(sync_out), .irq(irq), .prd_evt(prd_evt),
    .shadow_load(shadow_load), .cnt_out(cnt_out),
    .act_prd_out(act_prd_out), .act_cmp_out(act_cmp_out)
  );

  typedef struct packed {
    logic [15:0] prd;
    logic [15:0] cmp;
    logic        low;
    logic [15:0] hi;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{16'd9,  16'd3,  1'b0, 16'd3},
    '{16'd9,  16'd0,  1'b0, 16'd0},
    '{16'd9,  16'd10, 1'b0, 16'd10},
    '{16'd9,  16'd12, 1'b0, 16'd10},
    '{16'd4,  16'd2,  1'b1, 16'd3},
    '{16'd15, 16'd8,  1'b0, 16'd8},
    '{16'd1,  16'd1,  1'b0, 16'd1},
    '{16'd0,  16'd0,  1'b0, 16'd0},
    '{16'd0,  16'd1,  1'b0, 16'd1},
    '{16'd7,  16'd7,  1'b1, 16'd1}
  };

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ctrl_v(input logic run, input logic low,
                                          input logic sen, input logic [1:0] sel);
    return W'({sel, sen, low, run});
  endfunction

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cnt(input int v);
    for (int i = 0; i < 300; i++) begin
      if (cnt_out == W'(v)) return;
      @(negedge clk);
    end
  endtask

  task automatic setup(input int p, input int c, input logic low);
    wr(3'd0, ctrl_v(1'b0, low, 1'b1, 2'd0));
    wr(3'd1, W'(p)); wr(3'd2, W'(c));
    wr(3'd3, W'(p)); wr(3'd4, W'(c));
    wr(3'd5, '0);
    @(negedge clk); sync_in = 1'b1;
    @(negedge clk); sync_in = 1'b0;
    wr(3'd0, ctrl_v(1'b1, low, 1'b0, 2'd0));
  endtask

  task automatic summary;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int hi, c0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; sync_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "cnt", cnt_out, 0);
    chk("R1", "pwm", pwm_out, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "evt", prd_evt, 0);
    chk("R1", "act_prd", act_prd_out, 0);
    chk("R1", "act_cmp", act_cmp_out, 0);
    chk("R1", "sync_out", sync_out, 0);
    repeat (3) @(negedge clk);
    chk("R8", "frozen after reset", cnt_out, 0);

    // R2 duty and polarity table
    for (int v = 0; v < NVEC; v++) begin
      setup(int'(VECS[v].prd), int'(VECS[v].cmp), VECS[v].low);
      hi = 0;
      for (int i = 0; i <= int'(VECS[v].prd); i++) begin
        hi += int'(pwm_out);
        @(negedge clk);
      end
      chk("R2", $sformatf("high count vec %0d", v), hi, VECS[v].hi);
      chk("R4", $sformatf("wrap vec %0d", v), cnt_out, 0);
    end

    // R3 shadow transfer only at match, direct write immediate
    setup(9, 3, 1'b0);
    wr(3'd3, 32'd5); wr(3'd4, 32'd2);
    chk("R3", "active held after shadow write", act_prd_out, 9);
    wait_cnt(9);
    chk("R3", "load strobe at match", shadow_load, 1);
    chk("R3", "active before edge", act_prd_out, 9);
    @(negedge clk);
    chk("R3", "period moved", act_prd_out, 5);
    chk("R3", "compare moved", act_cmp_out, 2);
    chk("R4", "wrap after match", cnt_out, 0);
    wr(3'd2, 32'd4);
    chk("R3", "direct compare write", act_cmp_out, 4);

    // R6 R7 event flag and interrupt
    wr(3'd0, ctrl_v(1'b0, 1'b0, 1'b1, 2'd0));
    wr(3'd6, 32'd0);
    wr(3'd7, 32'd3);
    chk("R6", "evt cleared", prd_evt, 0);
    chk("R7", "irq cleared", irq, 0);
    wr(3'd0, ctrl_v(1'b1, 1'b0, 1'b1, 2'd0));
    wait_cnt(5);
    @(negedge clk);
    chk("R6", "evt set at match", prd_evt, 1);
    chk("R7", "irq held low when disabled", irq, 0);
    wr(3'd0, ctrl_v(1'b0, 1'b0, 1'b1, 2'd0));
    wr(3'd6, 32'd1);
    @(negedge clk);
    chk("R7", "irq from pending evt", irq, 1);
    wr(3'd7, 32'd2);
    chk("R7", "irq cleared alone", irq, 0);
    @(negedge clk);
    chk("R7", "irq sets again from pending evt", irq, 1);
    wr(3'd7, 32'd3);
    @(negedge clk);
    chk("R7", "both cleared", irq, 0);
    chk("R6", "evt cleared again", prd_evt, 0);
    wr(3'd6, 32'd0);

    // R5 sync reload, R9 pass-through
    wr(3'd5, 32'd4);
    wr(3'd0, ctrl_v(1'b1, 1'b0, 1'b1, 2'd0));
    wait_cnt(1);
    sync_in = 1'b1;
    #1 chk("R9", "pass-through", sync_out, 1);
    @(negedge clk); sync_in = 1'b0;
    chk("R5", "reload from phase", cnt_out, 4);

    // R5 ignored when disabled
    wr(3'd0, ctrl_v(1'b1, 1'b0, 1'b0, 2'd0));
    wait_cnt(2);
    sync_in = 1'b1;
    @(negedge clk); sync_in = 1'b0;
    chk("R5", "sync ignored when disabled", cnt_out, 3);

    // R5 R6 sync at the match cycle
    wr(3'd0, ctrl_v(1'b0, 1'b0, 1'b1, 2'd0));
    wr(3'd7, 32'd3);
    wr(3'd5, 32'd3);
    wr(3'd3, 32'd7);
    wr(3'd0, ctrl_v(1'b1, 1'b0, 1'b1, 2'd0));
    wait_cnt(5);
    sync_in = 1'b1;
    @(negedge clk); sync_in = 1'b0;
    chk("R5", "sync wins over wrap", cnt_out, 3);
    chk("R6", "evt despite sync", prd_evt, 1);
    chk("R3", "transfer despite sync", act_prd_out, 7);

    // R10 suppression by early syncs
    wr(3'd0, ctrl_v(1'b0, 1'b0, 1'b1, 2'd0));
    wr(3'd7, 32'd3);
    wr(3'd5, 32'd0);
    wr(3'd3, 32'd6);
    wr(3'd0, ctrl_v(1'b1, 1'b0, 1'b1, 2'd0));
    for (int r = 0; r < 5; r++) begin
      wait_cnt(5);
      sync_in = 1'b1;
      @(negedge clk); sync_in = 1'b0;
    end
    chk("R10", "no event under early syncs", prd_evt, 0);
    chk("R10", "period not transferred", act_prd_out, 7);
    wait_cnt(7);
    chk("R10", "strobe once syncs stop", shadow_load, 1);
    @(negedge clk);
    chk("R10", "pending transfer done", act_prd_out, 6);
    chk("R10", "event after release", prd_evt, 1);

    // R9 match select and off select
    wr(3'd0, ctrl_v(1'b1, 1'b0, 1'b0, 2'd1));
    wait_cnt(6);
    chk("R9", "match pulse out", sync_out, 1);
    @(negedge clk);
    chk("R9", "match pulse ends", sync_out, 0);
    wr(3'd0, ctrl_v(1'b1, 1'b0, 1'b0, 2'd2));
    sync_in = 1'b1;
    #1 chk("R9", "off select", sync_out, 0);
    @(negedge clk); sync_in = 1'b0;

    // R8 run bit freezes
    wr(3'd0, ctrl_v(1'b0, 1'b0, 1'b0, 2'd0));
    c0 = int'(cnt_out);
    repeat (5) @(negedge clk);
    chk("R8", "counter frozen", cnt_out, W'(c0));

    summary();
    $finish;
  end
endmodule